// File: doc/BRIEF.md
# Ethernet Receive Frame-End Checker

This block sits behind a receive deserializer and judges each incoming Ethernet frame at the moment the carrier drops. A start strobe opens a frame. Every bit offered with the valid strobe after that is fed into a running bit-serial CRC-32. The block also counts the bits. Each time a whole octet completes, it keeps a copy of the CRC register. When the end indication arrives, the block uses that octet-boundary copy to judge the frame. Up to seven trailing dribble bits therefore never disturb the check.

One clock after the end of the frame, the block raises a done strobe together with per-frame status. The status says whether the frame is accepted or discarded. It also flags a CRC error, a non-octet alignment error and a short frame, and it raises a receive-event flag. Two saturating counters keep totals of alignment errors and CRC errors. After every frame the block goes back to hunt mode and ignores traffic until the next start strobe. A minimum length in octets and a keep-short control decide what happens to undersized frames. The CRC check always runs; a consumer that does not care about it can ignore the flags.

Top module: `eth_rx_frame_check`

## Requirements
- R1: After reset, `hunting` is 1, `frame_done` and all status flags are 0, and both error counters are 0.
- R2: While hunting, `rx_valid` and `rx_end` have no effect: no `frame_done` appears and the counters do not change. A `rx_start` sampled while hunting opens a frame, and `hunting` reads 0 from the next cycle.
- R3: Each bit sampled with `rx_valid` updates a CRC-32 register with polynomial 0x04C11DB7, preset to all ones. The register shifts left, and its feedback is the register's bit 31 XOR the input bit. A frame's CRC is good when the copy taken at the last complete octet boundary equals 0xC704DD7B. A frame with zero whole octets is CRC-bad.
- R4: When `rx_end` is sampled during a frame, `frame_done` is high for exactly the following cycle, together with the status flags, and `hunting` is 1 in that cycle. A data bit offered in the same cycle as `rx_end` is not taken.
- R5: If a frame ends 1 to 7 bits past an octet boundary and the CRC at that boundary is good, the block reports no error flag and changes neither counter.
- R6: If a frame ends off an octet boundary and the CRC is bad, `st_align_err` is 1, `st_crc_err` is 0, and `align_err_cnt` increments.
- R7: If a frame ends on an octet boundary and the CRC is bad, `st_crc_err` is 1, `st_align_err` is 0, and `crc_err_cnt` increments.
- R8: `st_short` is 1 when the whole-octet count is below `min_len`. Such a frame gives `frame_discard` unless `keep_short` is 1; every other frame gives `frame_accept`. The error flags and counters apply to short frames too.
- R9: Both error counters are CNT_W bits wide (default 16) and hold at all ones instead of wrapping.
- R10: `rx_event` is high with `frame_done` whenever the frame is accepted or its CRC is bad, and low otherwise.
- R11: A `rx_start` sampled inside an open frame is ignored: it neither restarts the CRC nor clears the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Qualifies rx_bit |
| rx_bit | input | 1 | Serial receive data |
| rx_end | input | 1 | Carrier dropped, frame ends |
| min_len | input | LEN_W | Minimum frame length in octets |
| keep_short | input | 1 | Deliver short frames instead of discarding |
| frame_done | output | 1 | One-cycle status strobe |
| frame_accept | output | 1 | Frame delivered |
| frame_discard | output | 1 | Frame dropped as short |
| st_crc_err | output | 1 | Octet-aligned CRC error |
| st_align_err | output | 1 | Non-octet-aligned frame with bad CRC |
| st_short | output | 1 | Frame below minimum length |
| rx_event | output | 1 | Receive-frame event |
| align_err_cnt | output | CNT_W | Saturating alignment error count |
| crc_err_cnt | output | CNT_W | Saturating CRC error count |
| hunting | output | 1 | Waiting for a frame start |

## Verification
A corrupted running CRC or a mis-timed octet snapshot shows up at the very next done strobe. It appears as a false error on a good frame, or as a missed error on a corrupted one. A residual bit count that is off by one turns a CRC error into an alignment error, or the reverse. It also steps the wrong counter in that same cycle. A broken state machine shows up on `hunting` one cycle after a start or an end, or as a done strobe that lasts two cycles or appears while no frame is open. Sweeping payload length, dribble count, corruption and the keep-short setting drives every path of the decision within a few hundred frames.

// File: rtl/eth_rxchk_pkg.sv
package eth_rxchk_pkg;

  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  // One serial CRC-32 step: shift left, fold in the polynomial on feedback.
  function automatic logic [31:0] crc32_bit(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ({32{c[31] ^ b}} & CRC_POLY);
  endfunction

  typedef enum logic {ST_HUNT = 1'b0, ST_RECV = 1'b1} rx_state_e;

endpackage

// File: rtl/rxchk_bitcnt.sv
module rxchk_bitcnt #(
  parameter int LEN_W = 16,
  localparam int CW = LEN_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [LEN_W-1:0] octets,
  output logic [2:0]       residual,
  output logic             octet_mark
);
  logic [CW-1:0] cnt;
  logic          at_max;

  assign at_max     = &cnt;
  assign octets     = cnt[CW-1:3];
  assign residual   = cnt[2:0];
  assign octet_mark = inc && !clear && !at_max && (cnt[2:0] == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (inc && !at_max)  cnt <= cnt + 1'b1;
  end

  // R4: each taken bit advances the residual count by exactly one
  a_r4_residual_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear && !at_max) |=> (residual == 3'($past(residual) + 3'd1)));

endmodule

// File: rtl/rxchk_crc.sv
module rxchk_crc
  import eth_rxchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        shift,
  input  logic        bit_in,
  input  logic        octet_mark,
  output logic [31:0] crc_run,
  output logic [31:0] crc_oct
);
  logic [31:0] crc_nxt;

  assign crc_nxt = crc32_bit(crc_run, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_run <= CRC_PRESET;
      crc_oct <= CRC_PRESET;
    end else if (load) begin
      crc_run <= CRC_PRESET;
      crc_oct <= CRC_PRESET;
    end else if (shift) begin
      crc_run <= crc_nxt;
      if (octet_mark) crc_oct <= crc_nxt;
    end
  end

  // R5: the octet-boundary copy moves only when an octet completes or a frame opens
  a_r5_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(shift && octet_mark)) |=> $stable(crc_oct));

  // R3: snapshot equals the running value right after an octet completes
  a_r3_snapshot_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift && octet_mark) |=> (crc_oct == crc_run));

endmodule

// File: rtl/rxchk_satcnt.sv
module rxchk_satcnt #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= '0;
    else if (inc && !(&q)) q <= q + 1'b1;
  end

  // R9: once full, the count never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&q) |=> (&q));

endmodule

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check
  import eth_rxchk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_end,
  input  logic [LEN_W-1:0] min_len,
  input  logic             keep_short,
  output logic             frame_done,
  output logic             frame_accept,
  output logic             frame_discard,
  output logic             st_crc_err,
  output logic             st_align_err,
  output logic             st_short,
  output logic             rx_event,
  output logic [CNT_W-1:0] align_err_cnt,
  output logic [CNT_W-1:0] crc_err_cnt,
  output logic             hunting
);
  rx_state_e        state;
  logic             open_frame, take_bit, close_frame;
  logic [LEN_W-1:0] octets;
  logic [2:0]       residual;
  logic             octet_mark;
  logic [31:0]      crc_run, crc_oct;
  logic             crc_bad, misaligned, too_short, drop, ev_align, ev_crc;

  assign open_frame  = (state == ST_HUNT) && rx_start;
  assign close_frame = (state == ST_RECV) && rx_end;
  assign take_bit    = (state == ST_RECV) && rx_valid && !rx_end;

  rxchk_bitcnt #(.LEN_W(LEN_W)) u_bitcnt (
    .clk(clk), .rst_n(rst_n), .clear(open_frame), .inc(take_bit),
    .octets(octets), .residual(residual), .octet_mark(octet_mark));

  rxchk_crc u_crc (
    .clk(clk), .rst_n(rst_n), .load(open_frame), .shift(take_bit),
    .bit_in(rx_bit), .octet_mark(octet_mark),
    .crc_run(crc_run), .crc_oct(crc_oct));

  assign crc_bad    = (crc_oct != CRC_RESIDUE);
  assign misaligned = (residual != 3'd0);
  assign too_short  = (octets < min_len);
  assign drop       = too_short && !keep_short;
  assign ev_align   = close_frame && crc_bad && misaligned;
  assign ev_crc     = close_frame && crc_bad && !misaligned;

  rxchk_satcnt #(.WIDTH(CNT_W)) u_align_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_align), .q(align_err_cnt));
  rxchk_satcnt #(.WIDTH(CNT_W)) u_crc_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_crc), .q(crc_err_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state <= ST_HUNT;
    else if (open_frame)  state <= ST_RECV;
    else if (close_frame) state <= ST_HUNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done    <= 1'b0;
      frame_accept  <= 1'b0;
      frame_discard <= 1'b0;
      st_crc_err    <= 1'b0;
      st_align_err  <= 1'b0;
      st_short      <= 1'b0;
      rx_event      <= 1'b0;
    end else begin
      frame_done    <= close_frame;
      frame_accept  <= close_frame && !drop;
      frame_discard <= close_frame && drop;
      st_crc_err    <= ev_crc;
      st_align_err  <= ev_align;
      st_short      <= close_frame && too_short;
      rx_event      <= close_frame && (!drop || crc_bad);
    end
  end

  assign hunting = (state == ST_HUNT);

  // R4: done lasts one cycle and the block is back in hunt with it
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r4_done_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> hunting);

  // R6: an alignment error is matched by a counter step (or saturation)
  a_r6_align_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && st_align_err) |->
      ((align_err_cnt == $past(align_err_cnt) + 1'b1) || (&align_err_cnt)));

  // R7: a CRC error is matched by a counter step (or saturation)
  a_r7_crc_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && st_crc_err) |->
      ((crc_err_cnt == $past(crc_err_cnt) + 1'b1) || (&crc_err_cnt)));

  // R8: a discard only ever comes from a short frame, and accept/discard split done
  a_r8_discard_short: assert property (@(posedge clk) disable iff (!rst_n)
    frame_discard |-> (st_short && frame_done && !frame_accept));

  // R2: no status strobe without an open frame in the previous cycle
  a_r2_no_done_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hunting) |-> !frame_done);

endmodule

// File: tb/test_eth_rx_frame_check.sv
module test_eth_rx_frame_check;
  localparam int LEN_W = 8;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 0, rx_valid = 0, rx_bit = 0, rx_end = 0, keep_short = 0;
  logic [LEN_W-1:0] min_len = 8'd7;
  logic frame_done, frame_accept, frame_discard, st_crc_err, st_align_err;
  logic st_short, rx_event, hunting;
  logic [CNT_W-1:0] align_err_cnt, crc_err_cnt;

  int total = 0, bad = 0;
  bit finished = 0;
  int exp_align = 0, exp_crc = 0;
  logic fbits [0:191];
  int   nbits;

  always #10 clk = ~clk;

  eth_rx_frame_check #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_eth_rx_frame_check (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_end(rx_end), .min_len(min_len), .keep_short(keep_short),
    .frame_done(frame_done), .frame_accept(frame_accept), .frame_discard(frame_discard),
    .st_crc_err(st_crc_err), .st_align_err(st_align_err), .st_short(st_short),
    .rx_event(rx_event), .align_err_cnt(align_err_cnt), .crc_err_cnt(crc_err_cnt),
    .hunting(hunting));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench form of the CRC step: conditional polynomial division
  function automatic logic [31:0] step(input logic [31:0] c, input logic b);
    logic top;
    top = c[31];
    c = c << 1;
    if (top != b) c = c ^ 32'h04C11DB7;
    return c;
  endfunction

  // Build: payload bytes LSB first, FCS (inverted CRC) MSB first, then dribble bits
  task automatic build(input int plen, input int drib, input bit corrupt, input int seed);
    logic [31:0] c;
    logic [7:0] by;
    c = 32'hFFFFFFFF;
    nbits = 0;
    for (int i = 0; i < plen; i++) begin
      by = 8'((seed * 29 + i * 53 + 7) & 255);
      for (int k = 0; k < 8; k++) begin
        fbits[nbits] = by[k];
        c = step(c, by[k]);
        nbits++;
      end
    end
    for (int k = 31; k >= 0; k--) begin
      fbits[nbits] = ~c[k];
      nbits++;
    end
    if (corrupt) fbits[nbits-9] = ~fbits[nbits-9];
    for (int k = 0; k < drib; k++) begin
      fbits[nbits] = 1'((seed + k) & 1);
      nbits++;
    end
  endtask

  task automatic open_frame();
    @(negedge clk) rx_start = 1;
    @(negedge clk) rx_start = 0;
  endtask

  task automatic send_bits(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      rx_valid = 1; rx_bit = fbits[i];
      @(negedge clk);
    end
    rx_valid = 0;
  endtask

  task automatic end_and_check(input bit e_crcbad, input bit e_mis, input bit e_short,
                               input bit ks);
    bit drop;
    drop = e_short && !ks;
    if (e_crcbad && e_mis && exp_align < int'(CMAX)) exp_align++;
    if (e_crcbad && !e_mis && exp_crc < int'(CMAX)) exp_crc++;
    rx_end = 1; rx_valid = 1; rx_bit = 1;  // R4: bit with end is not taken
    @(negedge clk);
    rx_end = 0; rx_valid = 0;
    chk("R4", "done", frame_done, 1);
    chk("R4", "hunting", hunting, 1);
    chk("R7", "crc_err", st_crc_err, e_crcbad && !e_mis);
    chk("R6", "align_err", st_align_err, e_crcbad && e_mis);
    chk("R5", "align_cnt", align_err_cnt, exp_align);
    chk("R9", "crc_cnt", crc_err_cnt, exp_crc);
    chk("R8", "short", st_short, e_short);
    chk("R8", "accept", frame_accept, !drop);
    chk("R8", "discard", frame_discard, drop);
    chk("R10", "event", rx_event, !drop || e_crcbad);
    @(negedge clk);
    chk("R4", "done_gone", frame_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "hunting", hunting, 1);
    chk("R1", "done", frame_done, 0);
    chk("R1", "align_cnt", align_err_cnt, 0);
    chk("R1", "crc_cnt", crc_err_cnt, 0);

    // R2: traffic while hunting is ignored
    rx_valid = 1; rx_bit = 1; rx_end = 1;
    @(negedge clk);
    rx_valid = 0; rx_end = 0;
    @(negedge clk);
    chk("R2", "no_done", frame_done, 0);
    chk("R2", "crc_cnt_hold", crc_err_cnt, 0);
    chk("R2", "still_hunt", hunting, 1);
    open_frame();
    chk("R2", "hunt_drops", hunting, 0);
    // empty frame: zero octets -> CRC bad, aligned, short
    end_and_check(1, 0, 1, 0);

    // R3/R5/R6/R7/R8/R10 sweep
    for (int ks = 0; ks < 2; ks++)
      for (int pl = 0; pl < 7; pl++)
        for (int d = 0; d < 8; d++)
          for (int cr = 0; cr < 2; cr++) begin
            keep_short = 1'(ks);
            build(pl, d, 1'(cr), pl * 8 + d + ks);
            open_frame();
            send_bits(0, nbits);
            end_and_check(1'(cr), d != 0, (pl + 4) < 7, 1'(ks));
          end

    // R11: a start strobe inside a frame is ignored
    keep_short = 0;
    build(5, 3, 0, 99);
    open_frame();
    send_bits(0, 20);
    rx_start = 1;
    send_bits(20, 21);
    rx_start = 0;
    send_bits(21, nbits);
    end_and_check(0, 1, 0, 0);

    // R9: push CRC counter into saturation with empty frames
    for (int n = 0; n < 18; n++) begin
      open_frame();
      end_and_check(1, 0, 1, 0);
    end
    chk("R9", "crc_sat", crc_err_cnt, int'(CMAX));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule